// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit microcontroller core. Six sources feed it: two active-low external pins, the overflow pulses of two timers, a combined serial flag and a combined timer-2 flag. Three software-writable registers hold the per-source priority bits, the external trigger types with the hardware-set flags, and the enable bits. From these the controller picks one winning source and raises a vector request that carries the source index.

The core answers a request with a one-cycle acknowledge. On that acknowledge the controller marks the winner's level as in service and clears the winner's flag when that flag is owned by hardware. A later one-cycle return strobe releases the innermost level that is in service. A low-level service can be interrupted only by a high-level request. A high-level service cannot be interrupted at all.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the priority, control and enable registers read 0, nothing is in service and `vecReq` is 0.
- R2: The priority register implements bits 4:0 only (bit i = source i is high level; source 5 is always low level), and the enable register implements bit 7 (global enable) and bits 5:0 (source i enable); every other bit reads 0 whatever is written.
- R3: No request is presented while the global enable bit is 0 or the enable bit of the pending source is 0.
- R4: Among pending sources of the same level, the lowest index wins; the index order is external 0 (0), timer 0 (1), external 1 (2), timer 1 (3), serial (4), timer 2 (5).
- R5: Any pending high-level source beats every pending low-level source.
- R6: `vecReq` is raised only when the winner's level is above the innermost level in service: nothing in service accepts either level, low in service accepts only high, and high in service accepts nothing.
- R7: With its type bit at 1 (control bit 0 for external 0, bit 2 for external 1), an external pin sampled high and then low on consecutive clocks sets its flag (control bit 1 or bit 3) on the clock after the low sample. A pin held low does not set the flag again.
- R8: With its type bit at 0, an external source requests for as long as its pin is sampled low, and its flag is not set.
- R9: An acknowledge of source 0, 1, 2 or 3 clears that source's flag (control bits 1, 5, 3, 7).
- R10: An acknowledge does not touch the serial or timer-2 inputs, so these sources request again once their level leaves service.
- R11: A return strobe releases the high level if it is in service, and otherwise the low level.
- R12: `vecIdx` carries the winning source index as a 3-bit binary number (0 to 5).
- R13: A one-cycle pulse on a timer overflow input sets that timer's flag (control bit 5 for timer 0, bit 7 for timer 1), and the flag then stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 priority, 1 control, 2 enable |
| regWrData | input | 8 | Register write data |
| ext0N | input | 1 | External pin 0, active low |
| ext1N | input | 1 | External pin 1, active low |
| tmr0Ovf | input | 1 | Timer 0 overflow pulse |
| tmr1Ovf | input | 1 | Timer 1 overflow pulse |
| serFlag | input | 1 | Combined serial receive/transmit flag |
| tmr2Flag | input | 1 | Combined timer-2 overflow/reload flag |
| vecAck | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Core returns from a service routine |
| priReg | output | 8 | Priority register read-back |
| ctlReg | output | 8 | Control register read-back (timer flags/run, external flags/types) |
| enReg | output | 8 | Enable register read-back |
| vecReq | output | 1 | Vector request to the core |
| vecIdx | output | 3 | Index of the winning source |

## Verification
The hardest state to reach from the ports is two nested services, with a high-level routine running on top of a low one while further requests of both levels wait. Only an ordered script of acknowledges and returns builds it. The bench drives one such script: it acknowledges a low serial request, lets a high external request preempt it, and shows that a second high request is held off. It then unwinds the services one return at a time and checks which vector reappears at each step. A sweep over every pending pattern of all six sources, crossed with every priority setting, covers the ordering within a level and between levels against a winner that the bench computes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NumSrc  = 6;
  localparam int IdxW    = $clog2(NumSrc);
  localparam int DataW   = 8;
  localparam int NumExt  = 2;
  localparam int NumPri  = 5;

  localparam logic [1:0] SelPri = 2'd0;
  localparam logic [1:0] SelCtl = 2'd1;
  localparam logic [1:0] SelEn  = 2'd2;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic [NumSrc-1:0] clrFlag;   // one-hot: clear the acknowledged flag
    logic              ackFire;
  } strobe_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DataW-1:0]  regWrData,
  input  logic [NumExt-1:0] extN,
  input  logic [NumExt-1:0] tmrOvf,
  input  logic              serFlag,
  input  logic              tmr2Flag,
  input  strobe_t           stb,
  output logic [DataW-1:0]  priReg,
  output logic [DataW-1:0]  ctlReg,
  output logic [DataW-1:0]  enReg,
  output logic [NumSrc-1:0] pendVec,
  output logic [NumSrc-1:0] hiMask
);
  logic [NumExt-1:0] extQ, extPrev, extFlag, extType;
  logic [NumExt-1:0] tmrFlag, tmrRun;
  logic [NumPri-1:0] priBits;
  logic              glbEn;
  logic [NumSrc-1:0] srcEn;
  logic [NumSrc-1:0] srcRaw;
  logic              wrPri, wrCtl, wrEn;

  assign wrPri = regWrEn && (regSel == SelPri);
  assign wrCtl = regWrEn && (regSel == SelCtl);
  assign wrEn  = regWrEn && (regSel == SelEn);

  // Pin sampling pipeline, idle level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extQ    <= '1;
      extPrev <= '1;
    end else begin
      extQ    <= extN;
      extPrev <= extQ;
    end
  end

  // External pin g is source 2g, timer g is source 2g+1
  for (genvar g = 0; g < NumExt; g++) begin : gPair
    logic fallSeen;
    assign fallSeen = extPrev[g] & ~extQ[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        extFlag[g] <= 1'b0;
        extType[g] <= 1'b0;
        tmrFlag[g] <= 1'b0;
        tmrRun[g]  <= 1'b0;
      end else begin
        if (extType[g] && fallSeen)   extFlag[g] <= 1'b1;
        else if (wrCtl)               extFlag[g] <= regWrData[1+2*g];
        else if (stb.clrFlag[2*g])    extFlag[g] <= 1'b0;

        if (tmrOvf[g])                tmrFlag[g] <= 1'b1;
        else if (wrCtl)               tmrFlag[g] <= regWrData[5+2*g];
        else if (stb.clrFlag[2*g+1])  tmrFlag[g] <= 1'b0;

        if (wrCtl) begin
          extType[g] <= regWrData[2*g];
          tmrRun[g]  <= regWrData[4+2*g];
        end
      end
    end

    assign srcRaw[2*g]   = extType[g] ? extFlag[g] : ~extQ[g];
    assign srcRaw[2*g+1] = tmrFlag[g];

    // R7: a sampled falling edge in edge mode sets the flag next clock
    a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
      (extType[g] && extPrev[g] && !extQ[g]) |=> extFlag[g]);
    // R9: an acknowledge clears the timer flag unless a new overflow lands
    a_r9_tmr_clear: assert property (@(posedge clk) disable iff (!rstN)
      (stb.clrFlag[2*g+1] && !tmrOvf[g] && !wrCtl) |=> !tmrFlag[g]);
    // R13: an overflow pulse always leaves the flag set
    a_r13_ovf_sets: assert property (@(posedge clk) disable iff (!rstN)
      tmrOvf[g] |=> tmrFlag[g]);
  end

  assign srcRaw[4] = serFlag;
  assign srcRaw[5] = tmr2Flag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priBits <= '0;
      glbEn   <= 1'b0;
      srcEn   <= '0;
    end else begin
      if (wrPri) priBits <= regWrData[NumPri-1:0];
      if (wrEn) begin
        glbEn <= regWrData[DataW-1];
        srcEn <= regWrData[NumSrc-1:0];
      end
    end
  end

  assign pendVec = srcRaw & srcEn & {NumSrc{glbEn}};
  assign hiMask  = {{(NumSrc-NumPri){1'b0}}, priBits};

  assign priReg = {{(DataW-NumPri){1'b0}}, priBits};
  assign ctlReg = {tmrFlag[1], tmrRun[1], tmrFlag[0], tmrRun[0],
                   extFlag[1], extType[1], extFlag[0], extType[0]};
  assign enReg  = {glbEn, {(DataW-1-NumSrc){1'b0}}, srcEn};
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] pendVec,
  input  logic [NumSrc-1:0] hiMask,
  input  logic              vecAck,
  input  logic              reti,
  output logic              vecReq,
  output logic [IdxW-1:0]   vecIdx,
  output strobe_t           stb
);
  logic [1:0]        inSvc;      // bit0 low level, bit1 high level
  logic [NumSrc-1:0] hiPend;
  logic [IdxW-1:0]   hiWin, loWin, winIdx;
  logic              hiAny, anyPend;
  logic [1:0]        curLevel, winLevel;
  logic [1:0]        retiMask, ackMask;

  assign hiPend  = pendVec & hiMask;
  assign anyPend = |pendVec;

  // Fixed polling order: lowest index first
  always_comb begin
    hiWin = '0;
    loWin = '0;
    hiAny = 1'b0;
    for (int i = NumSrc - 1; i >= 0; i--) begin
      if (hiPend[i]) begin
        hiWin = IdxW'(i);
        hiAny = 1'b1;
      end
      if (pendVec[i]) loWin = IdxW'(i);
    end
  end

  assign winIdx   = hiAny ? hiWin : loWin;
  assign winLevel = hiAny ? 2'd2 : 2'd1;
  assign curLevel = inSvc[1] ? 2'd2 : (inSvc[0] ? 2'd1 : 2'd0);
  assign vecReq   = anyPend && (winLevel > curLevel);
  assign vecIdx   = winIdx;

  always_comb begin
    stb.ackFire = vecReq && vecAck;
    stb.clrFlag = '0;
    if (stb.ackFire) stb.clrFlag[winIdx] = 1'b1;
  end

  assign retiMask = !reti ? 2'b00 : (inSvc[1] ? 2'b10 : 2'b01);
  assign ackMask  = !stb.ackFire ? 2'b00 : (hiAny ? 2'b10 : 2'b01);

  always_ff @(posedge clk) begin
    if (!rstN) inSvc <= '0;
    else       inSvc <= (inSvc & ~retiMask) | ackMask;
  end

  // R6: nothing may be requested while the high level is in service
  a_r6_no_preempt_high: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> !inSvc[1]);
  // R6: a low service never starts underneath a running high service
  a_r6_low_not_nested: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSvc[0]) |-> !$past(inSvc[1]));
  // R11: a return with high in service leaves the low level untouched
  a_r11_release_inner: assert property (@(posedge clk) disable iff (!rstN)
    (reti && inSvc[1] && !stb.ackFire) |=> (!inSvc[1] && inSvc[0] == $past(inSvc[0])));
  // R9: at most one flag is cleared per acknowledge
  a_r9_one_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.clrFlag));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [7:0] regWrData,
  input  logic       ext0N,
  input  logic       ext1N,
  input  logic       tmr0Ovf,
  input  logic       tmr1Ovf,
  input  logic       serFlag,
  input  logic       tmr2Flag,
  input  logic       vecAck,
  input  logic       reti,
  output logic [7:0] priReg,
  output logic [7:0] ctlReg,
  output logic [7:0] enReg,
  output logic       vecReq,
  output logic [2:0] vecIdx
);
  strobe_t           stb;
  logic [NumSrc-1:0] pendVec, hiMask;

  irq_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .extN      ({ext1N, ext0N}),
    .tmrOvf    ({tmr1Ovf, tmr0Ovf}),
    .serFlag   (serFlag),
    .tmr2Flag  (tmr2Flag),
    .stb       (stb),
    .priReg    (priReg),
    .ctlReg    (ctlReg),
    .enReg     (enReg),
    .pendVec   (pendVec),
    .hiMask    (hiMask)
  );

  irq_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .pendVec (pendVec),
    .hiMask  (hiMask),
    .vecAck  (vecAck),
    .reti    (reti),
    .vecReq  (vecReq),
    .vecIdx  (vecIdx),
    .stb     (stb)
  );

  // R4: the presented vector names a source that is really pending
  a_r4_win_pending: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> pendVec[vecIdx]);
  // R3: requests require the global enable
  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> enReg[7]);
  // R12: the index stays inside the source range
  a_r12_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> (vecIdx < 3'(NumSrc)));
endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic       ext0N = 1'b1, ext1N = 1'b1;
  logic       tmr0Ovf = 1'b0, tmr1Ovf = 1'b0;
  logic       serFlag = 1'b0, tmr2Flag = 1'b0;
  logic       vecAck = 1'b0, reti = 1'b0;
  logic [7:0] priReg, ctlReg, enReg;
  logic       vecReq;
  logic [2:0] vecIdx;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk;   // 125 MHz

  irq_nest_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ext0N(ext0N), .ext1N(ext1N),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .serFlag(serFlag),
    .tmr2Flag(tmr2Flag), .vecAck(vecAck), .reti(reti),
    .priReg(priReg), .ctlReg(ctlReg), .enReg(enReg),
    .vecReq(vecReq), .vecIdx(vecIdx)
  );

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic pulseAck();
    vecAck = 1'b1; tick(1); vecAck = 1'b0;
  endtask

  task automatic pulseReti();
    reti = 1'b1; tick(1); reti = 1'b0;
  endtask

  // Expected arbitration with nothing in service: {req, idx}
  function automatic int expWin(input logic [5:0] pend, input logic [4:0] pri);
    logic [5:0] hi;
    hi = pend & {1'b0, pri};
    if (pend == 6'd0) return 0;
    for (int i = 0; i < 6; i++) if (hi[i]) return 8 + i;
    for (int i = 0; i < 6; i++) if (pend[i]) return 8 + i;
    return 0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin : stim
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 pri", priReg, 0);
    check("R1 ctl", ctlReg, 0);
    check("R1 en", enReg, 0);
    check("R1 vecReq", vecReq, 0);

    // R2 reserved bits
    wrReg(2'd0, 8'hFF);
    check("R2 pri readback", priReg, 8'h1F);
    wrReg(2'd2, 8'hFF);
    check("R2 en readback", enReg, 8'hBF);
    wrReg(2'd0, 8'h00);

    // R3 gating with the timer-2 source
    tmr2Flag = 1'b1;
    wrReg(2'd2, 8'h3F);
    check("R3 global off", vecReq, 0);
    wrReg(2'd2, 8'h9F);
    check("R3 source off", vecReq, 0);
    wrReg(2'd2, 8'hA0);
    check("R3 enabled req", vecReq, 1);
    check("R3 enabled idx", vecIdx, 5);
    tmr2Flag = 1'b0;
    wrReg(2'd2, 8'hBF);

    // R4 R5 R12 sweep: all pending patterns x all priority settings
    for (int pr = 0; pr < 32; pr++) begin
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pv;
        int e;
        pv = 6'(p);
        ext0N = ~pv[0]; ext1N = ~pv[2];
        serFlag = pv[4]; tmr2Flag = pv[5];
        wrReg(2'd1, {pv[3], 1'b0, pv[1], 5'b0});
        wrReg(2'd0, 8'(pr));
        e = expWin(pv, 5'(pr));
        chkCnt++;
        if (vecReq != e[3] || (e[3] && vecIdx != 3'(e))) begin
          errCnt++;
          $display("FAIL R4/R5/R12 p=%0d pri=%0d: actual=%0d/%0d expected=%0d/%0d",
                   p, pr, vecReq, vecIdx, e[3], e[2:0]);
        end
      end
    end
    ext0N = 1'b1; ext1N = 1'b1; serFlag = 1'b0; tmr2Flag = 1'b0;
    wrReg(2'd1, 8'h00);
    wrReg(2'd0, 8'h00);
    tick(1);
    check("R4 sweep idle", vecReq, 0);

    // R13 and R9: timer 0 overflow, acknowledge clears it
    tmr0Ovf = 1'b1; tick(1); tmr0Ovf = 1'b0;
    check("R13 tf0 set", ctlReg[5], 1);
    tick(2);
    check("R13 tf0 held", ctlReg[5], 1);
    check("R12 timer0 idx", vecIdx, 1);
    pulseAck();
    check("R9 tf0 cleared", ctlReg[5], 0);
    check("R9 no request left", vecReq, 0);
    pulseReti();
    tmr1Ovf = 1'b1; tick(1); tmr1Ovf = 1'b0;
    check("R13 tf1 set", ctlReg[7], 1);
    pulseAck();
    check("R9 tf1 cleared", ctlReg[7], 0);
    pulseReti();

    // R10: timer-2 request survives its acknowledge
    tmr2Flag = 1'b1; tick(1);
    pulseAck();
    check("R6 low blocks low", vecReq, 0);
    pulseReti();
    check("R10 t2 requests again", vecReq, 1);
    check("R10 t2 idx", vecIdx, 5);
    tmr2Flag = 1'b0; tick(1);

    // R6 R11: nested services
    serFlag = 1'b1; tick(1);
    pulseAck();                         // low level in service
    check("R6 low svc blocks low", vecReq, 0);
    wrReg(2'd0, 8'h09);                 // ext0 and timer1 high
    ext0N = 1'b0; tick(1);
    check("R6 high preempts low", vecReq, 1);
    check("R6 preempt idx", vecIdx, 0);
    pulseAck();                         // high level in service
    tmr1Ovf = 1'b1; tick(1); tmr1Ovf = 1'b0;
    check("R6 high blocks high", vecReq, 0);
    pulseReti();                        // release high, low remains
    check("R11 high released", vecReq, 1);
    check("R11 ext0 again", vecIdx, 0);
    ext0N = 1'b1; tick(1);
    check("R5 timer1 high idx", vecIdx, 3);
    pulseAck();
    check("R9 tf1 nested clear", ctlReg[7], 0);
    pulseReti();                        // high released, low still in service
    check("R11 low still held", vecReq, 0);
    pulseReti();                        // low released
    check("R11 low released", vecReq, 1);
    check("R10 serial idx", vecIdx, 4);
    serFlag = 1'b0;
    wrReg(2'd0, 8'h00);

    // R7 falling-edge mode on external 0
    wrReg(2'd1, 8'h01);
    ext0N = 1'b0; tick(1);
    check("R7 not yet set", ctlReg[1], 0);
    tick(1);
    check("R7 flag set", ctlReg[1], 1);
    check("R7 vector idx", vecIdx, 0);
    pulseAck();
    check("R9 ext0 flag cleared", ctlReg[1], 0);
    pulseReti();
    tick(3);
    check("R7 held low no reset", ctlReg[1], 0);
    check("R7 no request", vecReq, 0);
    ext0N = 1'b1; tick(2);

    // R7 on external 1 as well
    wrReg(2'd1, 8'h04);
    ext1N = 1'b0; tick(2);
    check("R7 ext1 flag", ctlReg[3], 1);
    check("R7 ext1 idx", vecIdx, 2);
    pulseAck();
    check("R9 ext1 cleared", ctlReg[3], 0);
    pulseReti();
    ext1N = 1'b1;

    // R8 level mode
    wrReg(2'd1, 8'h00);
    ext1N = 1'b0; tick(2);
    check("R8 level req", vecReq, 1);
    check("R8 level idx", vecIdx, 2);
    check("R8 no flag", ctlReg[3], 0);
    ext1N = 1'b1; tick(1);
    check("R8 level gone", vecReq, 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule